// File: doc/BRIEF.md
# IDE DMA Transfer Sequencer

This block runs one IDE DMA transfer as a series of chunks. A start command gives the transfer type, whether the drive is a fixed disk or a packet (optical) drive, the sector count, the starting LBA and the packet byte size. From these the block loads a signed count of bytes still owed and clears a progress index. It then sets its active flag and pulses a kick toward the descriptor-driven DMA channel.

Each time the channel offers a chunk, the block decides what to do with it. It can issue a read, write or trim request to the sector adapter at the correct byte offset. It can copy a non-block packet payload straight to memory. It can close the chunk or finish the whole transfer. If the channel has run ahead of the drive, it reports that it has gone idle. When the sector adapter answers, the block makes the same decision again, this time for a chunk that is already spent. It either finishes, closes the chunk, or aborts on an error. Descriptor fetching stays with the channel.

Top module: `ide_dma_sequencer`

## Requirements
- R1: After reset, active, status and every pulse output (reqValid, dmaKick, dmaEnd, chanIdle, dmaErr, cmdOk, irq) are 0.
- R2: A start accepted in the ready state loads the remaining count (packet size for a packet drive, sector count times 512 for a disk) and clears the index. On the next cycle it shows dmaKick high for one cycle, active 1 and status 0. A start that arrives while an adapter request is outstanding is ignored.
- R3: A chunk that arrives while active is 0 gives a one-cycle chanIdle pulse, with no dmaEnd, no request and no change to status.
- R4: For a disk transfer with bytes remaining, a nonzero chunk issues a request. reqOp is the start command (0 read, 1 write, 2 trim), reqOffset is LBA*512 plus the index, and reqLen is the chunk length.
- R5: For a packet transfer with bytes remaining and an LBA other than all ones, a nonzero chunk issues a read (reqOp 0) at LBA*2048 plus the index.
- R6: Each issued request lowers the remaining count by the chunk length and raises the index by the same amount. The count may go below zero.
- R7: When a chunk or an adapter completion finds the remaining count at zero or below, the transfer finishes. A disk sets status to 0x50 and pulses irq. A packet drive pulses cmdOk instead. In both cases active clears and dmaEnd pulses.
- R8: A zero-length chunk with bytes remaining pulses only dmaEnd, and active stays 1.
- R9: An error-free adapter completion with bytes remaining pulses only dmaEnd, and the transfer continues with the next chunk.
- R10: A packet transfer whose LBA is all ones answers a nonzero chunk, in a single cycle, with a request of reqOp 3 (copy to memory) whose length is the smaller of the remaining count and the chunk length. In the same cycle it pulses cmdOk and dmaEnd and clears active.
- R11: An adapter completion with reqErr set pulses dmaErr and dmaEnd, sets status to 0x41 and clears active.
- R12: A disk transfer started with command code 3 answers its first nonzero chunk exactly as R11 does, and issues no request.
- R13: A chunk offered while an adapter request is outstanding is ignored, and at most one request is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start a new transfer |
| startCmd | input | 2 | Command: 0 read, 1 write, 2 trim, 3 invalid |
| startIsPacket | input | 1 | 1 for a packet drive, 0 for a disk |
| startSectors | input | SECT_W | Disk sector count |
| startLba | input | LBA_W | Starting block address (all ones = non-block packet data) |
| startPktSize | input | PKT_W | Packet transfer size in bytes |
| chunkValid | input | 1 | Channel offers a chunk |
| chunkLen | input | LEN_W | Chunk length in bytes |
| reqDone | input | 1 | Sector adapter finished the outstanding request |
| reqErr | input | 1 | Error flag, valid with reqDone |
| reqValid | output | 1 | Request pulse to the adapter |
| reqOp | output | 2 | 0 read, 1 write, 2 trim, 3 copy to memory |
| reqOffset | output | OFF_W | Storage byte offset |
| reqLen | output | LEN_W | Request length in bytes |
| dmaKick | output | 1 | Kick the DMA channel after a start |
| dmaEnd | output | 1 | Current chunk closed |
| chanIdle | output | 1 | Chunk arrived before the transfer was active |
| dmaErr | output | 1 | Transfer aborted on error |
| cmdOk | output | 1 | Packet command completed |
| irq | output | 1 | Disk completion interrupt |
| status | output | 8 | Drive status byte |
| active | output | 1 | Transfer in progress |

## Verification
The bench targets the boundaries of the remaining count. These are a last chunk that overshoots the count, a zero-length chunk, and a completion that lands exactly on zero. A design that tests for "equal to zero" rather than "zero or below" would never finish after an overshoot. A design that treats a zero-length chunk as the end of the transfer would clear active too early. The bench also checks a chunk before any start, which must go idle without closing the chunk, and both offset scalings. A disk/packet shift swap would show up as a wrong reqOffset. Further cases are the all-ones LBA copy, where a missing minimum would send the full chunk length, and the adapter-error and invalid-command paths, where a design might keep active set or keep issuing requests.

// File: rtl/ide_seq_pkg.sv
package ide_seq_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_TRIM  = 2'd2,
    OP_COPY  = 2'd3
  } op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic issue;
    logic copy;
  } dp_strobe_t;

  localparam logic [7:0] STAT_DONE = 8'h50;  // ready | seek complete
  localparam logic [7:0] STAT_FAIL = 8'h41;  // ready | error

endpackage

// File: rtl/ide_seq_datapath.sv
module ide_seq_datapath
  import ide_seq_pkg::*;
#(
  parameter int LEN_W         = 16,
  parameter int SECT_W        = 16,
  parameter int LBA_W         = 32,
  parameter int PKT_W         = 24,
  parameter int SECTOR_SHIFT  = 9,
  parameter int PACKET_SHIFT  = 11
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  dp_strobe_t                             strobe,
  input  logic [1:0]                             startCmd,
  input  logic                                   startIsPacket,
  input  logic [SECT_W-1:0]                      startSectors,
  input  logic [LBA_W-1:0]                       startLba,
  input  logic [PKT_W-1:0]                       startPktSize,
  input  logic [LEN_W-1:0]                       chunkLen,
  output logic                                   remLeZero,
  output logic                                   chunkZero,
  output logic                                   nonBlock,
  output logic                                   isPacket,
  output logic                                   cmdBad,
  output logic [1:0]                             reqOp,
  output logic [LBA_W+PACKET_SHIFT:0]            reqOffset,
  output logic [LEN_W-1:0]                       reqLen
);

  localparam int DISK_BYTES_W = SECT_W + SECTOR_SHIFT;
  localparam int REM_W  = ((DISK_BYTES_W > PKT_W) ? DISK_BYTES_W : PKT_W) + 2;
  localparam int OFF_W  = LBA_W + PACKET_SHIFT + 1;

  logic signed [REM_W-1:0] remQ;
  logic [REM_W-1:0]        idxQ;
  logic [LBA_W-1:0]        lbaQ;
  logic                    pktQ;
  logic [1:0]              cmdQ;

  logic signed [REM_W-1:0] lenExt;
  logic [OFF_W-1:0]        baseOff;
  logic [OFF_W-1:0]        offNow;
  logic [LEN_W-1:0]        copyLen;

  assign lenExt = $signed({{(REM_W-LEN_W){1'b0}}, chunkLen});

  // byte offset: block address scaled by the drive's block size, plus progress
  always_comb begin
    if (pktQ)
      baseOff = {{(OFF_W-LBA_W-PACKET_SHIFT){1'b0}}, lbaQ, {PACKET_SHIFT{1'b0}}};
    else
      baseOff = {{(OFF_W-LBA_W-SECTOR_SHIFT){1'b0}}, lbaQ, {SECTOR_SHIFT{1'b0}}};
    offNow = baseOff + {{(OFF_W-REM_W){1'b0}}, idxQ};
  end

  // direct copy never exceeds what is still owed
  assign copyLen   = (lenExt > remQ) ? remQ[LEN_W-1:0] : chunkLen;

  assign remLeZero = remQ[REM_W-1] || (remQ == '0);
  assign chunkZero = (chunkLen == '0);
  assign nonBlock  = &lbaQ;
  assign isPacket  = pktQ;
  assign cmdBad    = (cmdQ == 2'd3);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remQ      <= '0;
      idxQ      <= '0;
      lbaQ      <= '0;
      pktQ      <= 1'b0;
      cmdQ      <= 2'd0;
      reqOp     <= 2'd0;
      reqOffset <= '0;
      reqLen    <= '0;
    end else begin
      if (strobe.load) begin
        idxQ <= '0;
        lbaQ <= startLba;
        pktQ <= startIsPacket;
        cmdQ <= startCmd;
        if (startIsPacket)
          remQ <= $signed({{(REM_W-PKT_W){1'b0}}, startPktSize});
        else
          remQ <= $signed({{(REM_W-DISK_BYTES_W){1'b0}}, startSectors,
                           {SECTOR_SHIFT{1'b0}}});
      end
      if (strobe.issue) begin
        remQ      <= remQ - lenExt;
        idxQ      <= idxQ + lenExt;
        reqOp     <= pktQ ? OP_READ : cmdQ;
        reqOffset <= offNow;
        reqLen    <= chunkLen;
      end
      if (strobe.copy) begin
        remQ      <= $signed({{(REM_W-LEN_W){1'b0}}, copyLen});
        reqOp     <= OP_COPY;
        reqOffset <= '0;
        reqLen    <= copyLen;
      end
    end
  end

endmodule

// File: rtl/ide_seq_control.sv
module ide_seq_control
  import ide_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic       chunkValid,
  input  logic       reqDone,
  input  logic       reqErr,
  input  logic       remLeZero,
  input  logic       chunkZero,
  input  logic       nonBlock,
  input  logic       isPacket,
  input  logic       cmdBad,
  output dp_strobe_t strobe,
  output logic       reqValid,
  output logic       dmaKick,
  output logic       dmaEnd,
  output logic       chanIdle,
  output logic       dmaErr,
  output logic       cmdOk,
  output logic       irq,
  output logic [7:0] status,
  output logic       active
);

  typedef enum logic {S_READY, S_WAIT} state_e;
  typedef enum logic [2:0] {
    D_NONE, D_START, D_PAUSE, D_FINISH, D_SLICE_END, D_COPY, D_FAIL, D_ISSUE
  } dec_e;

  state_e stateQ;
  dec_e   dec;
  logic   startTake, chunkTake, doneTake, evaluate, lenZero;

  assign startTake = startValid && (stateQ == S_READY);
  assign chunkTake = chunkValid && (stateQ == S_READY) && !startValid;
  assign doneTake  = reqDone && (stateQ == S_WAIT);
  assign evaluate  = chunkTake || doneTake;
  // a completed request re-enters the decision with its chunk already spent
  assign lenZero   = doneTake ? 1'b1 : chunkZero;

  always_comb begin
    dec = D_NONE;
    if (startTake)                 dec = D_START;
    else if (doneTake && reqErr)   dec = D_FAIL;
    else if (evaluate) begin
      if (!active)                 dec = D_PAUSE;
      else if (remLeZero)          dec = D_FINISH;
      else if (lenZero)            dec = D_SLICE_END;
      else if (isPacket && nonBlock) dec = D_COPY;
      else if (!isPacket && cmdBad)  dec = D_FAIL;
      else                         dec = D_ISSUE;
    end
  end

  always_comb begin
    strobe.load  = (dec == D_START);
    strobe.issue = (dec == D_ISSUE);
    strobe.copy  = (dec == D_COPY);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= S_READY;
      reqValid <= 1'b0;
      dmaKick  <= 1'b0;
      dmaEnd   <= 1'b0;
      chanIdle <= 1'b0;
      dmaErr   <= 1'b0;
      cmdOk    <= 1'b0;
      irq      <= 1'b0;
      status   <= 8'h00;
      active   <= 1'b0;
    end else begin
      reqValid <= 1'b0;
      dmaKick  <= 1'b0;
      dmaEnd   <= 1'b0;
      chanIdle <= 1'b0;
      dmaErr   <= 1'b0;
      cmdOk    <= 1'b0;
      irq      <= 1'b0;
      if (doneTake) stateQ <= S_READY;
      case (dec)
        D_START: begin
          active  <= 1'b1;
          dmaKick <= 1'b1;
          status  <= 8'h00;
        end
        D_PAUSE: chanIdle <= 1'b1;
        D_FINISH: begin
          active <= 1'b0;
          dmaEnd <= 1'b1;
          if (isPacket) begin
            cmdOk <= 1'b1;
          end else begin
            status <= STAT_DONE;
            irq    <= 1'b1;
          end
        end
        D_SLICE_END: dmaEnd <= 1'b1;
        D_COPY: begin
          reqValid <= 1'b1;
          cmdOk    <= 1'b1;
          dmaEnd   <= 1'b1;
          active   <= 1'b0;
        end
        D_FAIL: begin
          dmaErr <= 1'b1;
          dmaEnd <= 1'b1;
          status <= STAT_FAIL;
          active <= 1'b0;
        end
        D_ISSUE: begin
          reqValid <= 1'b1;
          stateQ   <= S_WAIT;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ide_dma_sequencer.sv
module ide_dma_sequencer
  import ide_seq_pkg::*;
#(
  parameter int LEN_W        = 16,
  parameter int SECT_W       = 16,
  parameter int LBA_W        = 32,
  parameter int PKT_W        = 24,
  parameter int SECTOR_SHIFT = 9,
  parameter int PACKET_SHIFT = 11,
  localparam int OFF_W       = LBA_W + PACKET_SHIFT + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [1:0]        startCmd,
  input  logic              startIsPacket,
  input  logic [SECT_W-1:0] startSectors,
  input  logic [LBA_W-1:0]  startLba,
  input  logic [PKT_W-1:0]  startPktSize,
  input  logic              chunkValid,
  input  logic [LEN_W-1:0]  chunkLen,
  input  logic              reqDone,
  input  logic              reqErr,
  output logic              reqValid,
  output logic [1:0]        reqOp,
  output logic [OFF_W-1:0]  reqOffset,
  output logic [LEN_W-1:0]  reqLen,
  output logic              dmaKick,
  output logic              dmaEnd,
  output logic              chanIdle,
  output logic              dmaErr,
  output logic              cmdOk,
  output logic              irq,
  output logic [7:0]        status,
  output logic              active
);

  dp_strobe_t strobe;
  logic remLeZero, chunkZero, nonBlock, isPacket, cmdBad;

  ide_seq_control i_control (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .chunkValid (chunkValid),
    .reqDone    (reqDone),
    .reqErr     (reqErr),
    .remLeZero  (remLeZero),
    .chunkZero  (chunkZero),
    .nonBlock   (nonBlock),
    .isPacket   (isPacket),
    .cmdBad     (cmdBad),
    .strobe     (strobe),
    .reqValid   (reqValid),
    .dmaKick    (dmaKick),
    .dmaEnd     (dmaEnd),
    .chanIdle   (chanIdle),
    .dmaErr     (dmaErr),
    .cmdOk      (cmdOk),
    .irq        (irq),
    .status     (status),
    .active     (active)
  );

  ide_seq_datapath #(
    .LEN_W        (LEN_W),
    .SECT_W       (SECT_W),
    .LBA_W        (LBA_W),
    .PKT_W        (PKT_W),
    .SECTOR_SHIFT (SECTOR_SHIFT),
    .PACKET_SHIFT (PACKET_SHIFT)
  ) i_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .startCmd      (startCmd),
    .startIsPacket (startIsPacket),
    .startSectors  (startSectors),
    .startLba      (startLba),
    .startPktSize  (startPktSize),
    .chunkLen      (chunkLen),
    .remLeZero     (remLeZero),
    .chunkZero     (chunkZero),
    .nonBlock      (nonBlock),
    .isPacket      (isPacket),
    .cmdBad        (cmdBad),
    .reqOp         (reqOp),
    .reqOffset     (reqOffset),
    .reqLen        (reqLen)
  );

endmodule

// File: rtl/ide_dma_sequencer_checker.sv
module ide_dma_sequencer_checker (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic [1:0] reqOp,
  input logic       dmaKick,
  input logic       dmaEnd,
  input logic       chanIdle,
  input logic       dmaErr,
  input logic       cmdOk,
  input logic       irq,
  input logic [7:0] status,
  input logic       active
);

  a_r2_kick_active: assert property (@(posedge clk) disable iff (!rstN)
    dmaKick |-> active && status == 8'h00);

  a_r7_irq_done: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> status == 8'h50 && !active && dmaEnd);

  a_r7_ok_done: assert property (@(posedge clk) disable iff (!rstN)
    cmdOk |-> !active && dmaEnd);

  a_r11_err_end: assert property (@(posedge clk) disable iff (!rstN)
    dmaErr |-> dmaEnd && status == 8'h41 && !active);

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    chanIdle |-> !dmaEnd && !reqValid && !active);

  a_r4_issue_live: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp != 2'd3) |-> active && !dmaEnd);

  a_r13_one_in_flight: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp != 2'd3) |=> !reqValid);

  a_r10_copy_ends: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 2'd3) |-> cmdOk && dmaEnd);

  a_r7_events_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({irq, cmdOk, dmaErr, chanIdle, dmaKick}));

  a_r7_active_drop: assert property (@(posedge clk) disable iff (!rstN)
    $fell(active) |-> (irq || cmdOk || dmaErr));

endmodule

bind ide_dma_sequencer ide_dma_sequencer_checker i_checker (.*);

// File: tb/test_ide_dma_sequencer.sv
module test_ide_dma_sequencer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [1:0]  startCmd = 2'd0;
  logic        startIsPacket = 1'b0;
  logic [15:0] startSectors = '0;
  logic [31:0] startLba = '0;
  logic [23:0] startPktSize = '0;
  logic        chunkValid = 1'b0;
  logic [15:0] chunkLen = '0;
  logic        reqDone = 1'b0;
  logic        reqErr = 1'b0;
  logic        reqValid;
  logic [1:0]  reqOp;
  logic [43:0] reqOffset;
  logic [15:0] reqLen;
  logic        dmaKick, dmaEnd, chanIdle, dmaErr, cmdOk, irq, active;
  logic [7:0]  status;

  ide_dma_sequencer i_ide_dma_sequencer (.*);

  always #10ns clk = ~clk;  // 50 MHz

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  // bench model of the transfer state
  longint mRem, mIdx, mLba;
  bit     mPkt, mActive;
  int     mCmd;
  int     mStatus;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nFails = nFails + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic expectOut(input string req, input bit rv, input int op, input longint off,
                           input longint rl, input bit endE, input bit idleE, input bit errE,
                           input bit okE, input bit irqE, input bit kickE);
    chk(req, "reqValid", reqValid, rv);
    chk(req, "dmaEnd",   dmaEnd,   endE);
    chk(req, "chanIdle", chanIdle, idleE);
    chk(req, "dmaErr",   dmaErr,   errE);
    chk(req, "cmdOk",    cmdOk,    okE);
    chk(req, "irq",      irq,      irqE);
    chk(req, "dmaKick",  dmaKick,  kickE);
    chk(req, "status",   status,   mStatus);
    chk(req, "active",   active,   mActive);
    if (rv) begin
      chk(req, "reqOp",  reqOp,  op);
      chk(req, "reqLen", reqLen, rl);
      if (op != 3) chk(req, "reqOffset", reqOffset, off);
    end
  endtask

  function automatic longint expOffset();
    return mPkt ? ((mLba << 11) + mIdx) : ((mLba << 9) + mIdx);
  endfunction

  task automatic doStart(input int cmd, input bit pkt, input int sect, input longint lba,
                         input int psize);
    @(negedge clk);
    startValid = 1'b1; startCmd = cmd[1:0]; startIsPacket = pkt;
    startSectors = sect[15:0]; startLba = lba[31:0]; startPktSize = psize[23:0];
    @(negedge clk);
    startValid = 1'b0;
    mRem = pkt ? longint'(psize) : longint'(sect) * 512;
    mIdx = 0; mLba = lba & 64'hFFFF_FFFF; mPkt = pkt; mCmd = cmd;
    mActive = 1'b1; mStatus = 0;
    expectOut("R2", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic finishModel(output bit okE, output bit irqE);
    okE = mPkt; irqE = !mPkt;
    if (!mPkt) mStatus = 8'h50;
    mActive = 1'b0;
  endtask

  task automatic sendChunk(input int len, input bit errResp, input bit poke);
    bit okE, irqE;
    longint off, cl;
    @(negedge clk);
    chunkValid = 1'b1; chunkLen = len[15:0];
    @(negedge clk);
    chunkValid = 1'b0;
    if (!mActive) begin
      expectOut("R3", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    end else if (mRem <= 0) begin
      finishModel(okE, irqE);
      expectOut("R7", 0, 0, 0, 0, 1, 0, 0, okE, irqE, 0);
    end else if (len == 0) begin
      expectOut("R8", 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    end else if (mPkt && mLba == 64'hFFFF_FFFF) begin
      cl = (longint'(len) > mRem) ? mRem : longint'(len);
      mActive = 1'b0;
      expectOut("R10", 1, 3, 0, cl, 1, 0, 0, 1, 0, 0);
    end else if (!mPkt && mCmd == 3) begin
      mActive = 1'b0; mStatus = 8'h41;
      expectOut("R12", 0, 0, 0, 0, 1, 0, 1, 0, 0, 0);
    end else begin
      off = expOffset();
      expectOut(mPkt ? "R5" : "R4", 1, mPkt ? 0 : mCmd, off, len, 0, 0, 0, 0, 0, 0);
      mRem = mRem - len;  // R6
      mIdx = mIdx + len;
      if (poke) begin
        chunkValid = 1'b1; chunkLen = 16'd77;
        @(negedge clk);
        chunkValid = 1'b0;
        expectOut("R13", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        startValid = 1'b1;
        @(negedge clk);
        startValid = 1'b0;
        expectOut("R2", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      end
      reqDone = 1'b1; reqErr = errResp;
      @(negedge clk);
      reqDone = 1'b0; reqErr = 1'b0;
      if (errResp) begin
        mActive = 1'b0; mStatus = 8'h41;
        expectOut("R11", 0, 0, 0, 0, 1, 0, 1, 0, 0, 0);
      end else if (mRem <= 0) begin
        finishModel(okE, irqE);
        expectOut("R7", 0, 0, 0, 0, 1, 0, 0, okE, irqE, 0);
      end else begin
        expectOut("R9", 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
      end
    end
  endtask

  initial begin
    mRem = 0; mIdx = 0; mLba = 0; mPkt = 0; mCmd = 0; mActive = 0; mStatus = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expectOut("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // chunk before any start
    sendChunk(256, 0, 0);

    // disk read, two sectors, with a zero-length chunk and a poke while busy
    doStart(0, 0, 2, 100, 0);
    sendChunk(512, 0, 0);
    sendChunk(0, 0, 0);
    sendChunk(512, 0, 1);
    sendChunk(64, 0, 0);

    // disk write, last chunk overshoots the count
    doStart(1, 0, 1, 32'h0012_3456, 0);
    sendChunk(1000, 0, 0);

    // disk trim with an adapter error
    doStart(2, 0, 4, 9, 0);
    sendChunk(512, 1, 0);

    // invalid command code
    doStart(3, 0, 1, 5, 0);
    sendChunk(512, 0, 0);

    // packet drive, block data
    doStart(0, 1, 0, 7, 3000);
    sendChunk(2048, 0, 0);
    sendChunk(2048, 0, 0);

    // packet drive, non-block data
    doStart(0, 1, 0, 32'hFFFF_FFFF, 300);
    sendChunk(1000, 0, 0);
    doStart(0, 1, 0, 32'hFFFF_FFFF, 5000);
    sendChunk(64, 0, 0);

    // random transfers
    for (int t = 0; t < 30; t++) begin
      bit pkt;
      longint lba;
      int cmd;
      pkt = $urandom % 2;
      if (pkt) lba = ($urandom % 4 == 0) ? 64'hFFFF_FFFF : longint'($urandom % 100000);
      else     lba = longint'($urandom);
      cmd = ($urandom % 8 == 0) ? 3 : int'($urandom % 3);
      doStart(cmd, pkt, 1 + int'($urandom % 6), lba, 1 + int'($urandom % 6000));
      for (int k = 0; k < 40 && mActive; k++) begin
        int len;
        len = ($urandom % 8 == 0) ? 0 : 1 + int'($urandom % 1500);
        sendChunk(len, ($urandom % 20) == 0, k == 1);
      end
      sendChunk(100, 0, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule